// File: doc/BRIEF.md
# Dual-Channel Converter Capture and Merge

This block sits between a dual pipelined analog-to-digital converter and the sample-processing fabric. It drives the converter's two-bit operating-mode pins, blanks the words that the converter produces while its pipeline refills or while it wakes from power-down, and turns the two 10-bit parallel sample buses into a single time-ordered stream. Each output word carries a signed sample, a channel tag and a flag marking the first word after a mode change.

The capture clock runs at the encode rate. In ping-pong mode the two channels sample on opposite encode phases, so each capture cycle brings one new word from one channel. In aligned mode both buses present a new pair together on the even phase, and the channel B word is emitted one cycle later. In single-channel mode only channel A is taken, one word per cycle. Samples leave through a valid/ready stream with a small buffer. The converter cannot be stalled, so when the buffer is full a newly captured word is dropped and the buffered words are kept in order. While `out_valid` is high and `out_ready` is low, the presented word holds steady.

Top module: `dual_adc_capture`

## Requirements
- R1: A synchronous active-high reset drives `adc_sel` to 00 (both channels powered down), empties the buffer and holds `out_valid` low.
- R2: `adc_sel` presents the value that `mode_req` had at the previous rising clock edge. The codes are 00 = both channels off, 01 = channel A only, 10 = ping-pong, 11 = aligned.
- R3: When `adc_sel` changes and no channel wakes up, the next 5 capture cycles are discarded.
- R4: When `adc_sel` leaves 00, or goes from 01 to 10 or 11, the next 10 capture cycles are discarded.
- R5: With `adc_sel` at 00 no word is produced, whatever is on the buses.
- R6: With `adc_sel` at 01 every live cycle yields one channel A word with tag 0. `b_bus` is ignored.
- R7: With `adc_sel` at 10 live cycles alternate between A and B, starting with A on the first live cycle. The tag is 0 for A and 1 for B.
- R8: With `adc_sel` at 11 both buses are taken together on even live cycles. The A word is emitted that cycle and the held B word the next cycle. The buses are ignored on odd cycles.
- R9: When `fmt_offset` is 1 the sample MSB (bit 9) is inverted to give two's complement. When it is 0 the sample passes unchanged.
- R10: `out_first` is 1 only on the first word captured after a change of `adc_sel`.
- R11: The buffer holds up to DEPTH words. A word captured while the buffer is full and not being read is dropped. The head word stays stable while `out_valid` is high and `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock at the encode rate |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested converter mode |
| fmt_offset | input | 1 | 1 = converter outputs offset binary |
| adc_sel | output | 2 | Mode pins driven to the converter |
| a_bus | input | 10 | Channel A sample bus |
| b_bus | input | 10 | Channel B sample bus |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 10 | Two's complement sample |
| out_chan | output | 1 | Channel tag, 0 = A, 1 = B |
| out_first | output | 1 | First word after a mode change |

## Verification
A change on `mode_req` reaches `adc_sel` at the next edge. The blanking window then covers exactly 5 or 10 cycles. A word on the buses during a live cycle is written at the edge that ends that cycle and is visible on the output right after that edge. An aligned B word appears one cycle later. The driver applies inputs at the falling edge and advances its own model of mode, window, phase and buffer fill through the same edge. The monitor samples a fraction of a cycle after the falling edge, pops one expected word for each handshake it sees, and checks that a stalled word has not moved.

// File: rtl/dac_cap_pkg.sv
package dac_cap_pkg;
  typedef enum logic [1:0] {
    M_OFF      = 2'b00,
    M_A_ONLY   = 2'b01,
    M_PINGPONG = 2'b10,
    M_ALIGN    = 2'b11
  } cap_mode_e;
endpackage

// File: rtl/cap_mode_ctrl.sv
module cap_mode_ctrl
  import dac_cap_pkg::*;
#(
  parameter int PIPE_LAT = 5,
  parameter int WAKE_LAT = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_req,
  input  logic       push,
  output cap_mode_e  sel,
  output logic       live,
  output logic       phase,
  output logic       first_pend
);
  localparam int MAXL = (WAKE_LAT > PIPE_LAT) ? WAKE_LAT : PIPE_LAT;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] blank_cnt;
  logic          load;
  logic          waking;

  assign load   = (mode_req != sel);
  // a channel comes out of power-down
  assign waking = (sel == M_OFF) || (sel == M_A_ONLY && mode_req[1]);
  assign live   = (blank_cnt == '0) && (sel != M_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel        <= M_OFF;
      blank_cnt  <= '0;
      phase      <= 1'b0;
      first_pend <= 1'b0;
    end else begin
      sel <= cap_mode_e'(mode_req);
      if (load)
        blank_cnt <= waking ? CW'(WAKE_LAT) : CW'(PIPE_LAT);
      else if (blank_cnt != '0)
        blank_cnt <= blank_cnt - 1'b1;
      // phase restarts at zero on the first live cycle
      phase <= (load || blank_cnt != '0) ? 1'b0 : ~phase;
      if (load)
        first_pend <= 1'b1;
      else if (push)
        first_pend <= 1'b0;
    end
  end

  // R3 R4: window never outlasts the wake latency
  p_window_bound_r4: assert property (@(posedge clk) disable iff (rst)
    blank_cnt <= CW'(MAXL));
endmodule

// File: rtl/cap_lane_sel.sv
module cap_lane_sel
  import dac_cap_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  cap_mode_e           sel,
  input  logic                live,
  input  logic                phase,
  input  logic                fmt_offset,
  input  logic [SAMPLE_W-1:0] a_bus,
  input  logic [SAMPLE_W-1:0] b_bus,
  output logic                push,
  output logic                push_chan,
  output logic [SAMPLE_W-1:0] push_data
);
  logic [SAMPLE_W-1:0] a_fix, b_fix, b_hold;

  // offset binary to two's complement: flip the MSB
  assign a_fix = fmt_offset ? {~a_bus[SAMPLE_W-1], a_bus[SAMPLE_W-2:0]} : a_bus;
  assign b_fix = fmt_offset ? {~b_bus[SAMPLE_W-1], b_bus[SAMPLE_W-2:0]} : b_bus;

  always_comb begin
    push      = 1'b0;
    push_chan = 1'b0;
    push_data = a_fix;
    unique case (sel)
      M_A_ONLY: begin
        push = live;
      end
      M_PINGPONG: begin
        push      = live;
        push_chan = phase;
        push_data = phase ? b_fix : a_fix;
      end
      M_ALIGN: begin
        push      = live;
        push_chan = phase;
        push_data = phase ? b_hold : a_fix;
      end
      default: push = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      b_hold <= '0;
    else if (sel == M_ALIGN && live && !phase)
      b_hold <= b_fix;
  end

  p_pd_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (sel == M_OFF) |-> !push);

  p_a_only_tag_r6: assert property (@(posedge clk) disable iff (rst)
    (push && sel == M_A_ONLY) |-> !push_chan);
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             rd, wr;

  assign rd_valid = (cnt != '0);
  assign rd       = rd_valid && rd_ready;
  assign wr       = wr_en && ((cnt != CW'(DEPTH)) || rd);
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(wr) - CW'(rd);
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= wr_data;
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/dual_adc_capture.sv
module dual_adc_capture
  import dac_cap_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int DEPTH    = 4,
  parameter int PIPE_LAT = 5,
  parameter int WAKE_LAT = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode_req,
  input  logic                fmt_offset,
  output logic [1:0]          adc_sel,
  input  logic [SAMPLE_W-1:0] a_bus,
  input  logic [SAMPLE_W-1:0] b_bus,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_chan,
  output logic                out_first
);
  localparam int WORD_W = SAMPLE_W + 2;

  cap_mode_e           sel;
  logic                live, phase, first_pend;
  logic                push, push_chan;
  logic [SAMPLE_W-1:0] push_data;
  logic [WORD_W-1:0]   head;

  cap_mode_ctrl #(.PIPE_LAT(PIPE_LAT), .WAKE_LAT(WAKE_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .mode_req(mode_req), .push(push),
    .sel(sel), .live(live), .phase(phase), .first_pend(first_pend)
  );

  cap_lane_sel #(.SAMPLE_W(SAMPLE_W)) u_lane (
    .clk(clk), .rst(rst), .sel(sel), .live(live), .phase(phase),
    .fmt_offset(fmt_offset), .a_bus(a_bus), .b_bus(b_bus),
    .push(push), .push_chan(push_chan), .push_data(push_data)
  );

  cap_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(push),
    .wr_data({first_pend, push_chan, push_data}),
    .rd_ready(out_ready), .rd_valid(out_valid), .rd_data(head)
  );

  assign adc_sel   = sel;
  assign out_first = head[WORD_W-1];
  assign out_chan  = head[WORD_W-2];
  assign out_data  = head[SAMPLE_W-1:0];

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && adc_sel == 2'b00));

  p_sel_follow_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (adc_sel == $past(mode_req)));

  p_align_pair_r8: assert property (@(posedge clk) disable iff (rst)
    (push && sel == M_ALIGN && !push_chan && mode_req == sel) |=> (push && push_chan));

  p_first_once_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_first) |=> !(out_valid && out_first));
endmodule

// File: tb/dual_adc_capture_bench.sv
`timescale 1ns/100ps
module dual_adc_capture_bench;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_req = 2'b00;
  logic       fmt_offset = 1'b0;
  logic [1:0] adc_sel;
  logic [9:0] a_bus = '0, b_bus = '0;
  logic       out_valid, out_ready = 1'b1;
  logic [9:0] out_data;
  logic       out_chan, out_first;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  // bench model state
  logic [1:0] bsel = 0;
  int         bblank = 0, bcnt = 0;
  logic       bphase = 0, bfirst = 0;
  logic [9:0] bhold = 0;

  always #2.5 clk = ~clk;

  dual_adc_capture u_dual_adc_capture (
    .clk(clk), .rst(rst), .mode_req(mode_req), .fmt_offset(fmt_offset),
    .adc_sel(adc_sel), .a_bus(a_bus), .b_bus(b_bus),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan), .out_first(out_first)
  );

  function automatic logic [9:0] fx(input logic [9:0] v);  // R9
    return fmt_offset ? {~v[9], v[8:0]} : v;
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=0x%0h expected=0x%0h", req, got, expv);
    end
  endtask

  // drive one capture cycle and advance the model through the edge
  task automatic step(input logic [1:0] m, input logic rdy);
    logic [9:0] a, b;
    logic [11:0] w;
    bit ep, pop, acc, load;
    logic nph;
    string tg;
    a = 10'($urandom); b = 10'($urandom);
    mode_req = m; out_ready = rdy; a_bus = a; b_bus = b;
    ep = 0; acc = 0; w = '0; tg = "";
    if (bblank == 0) begin
      case (bsel)
        2'b01: begin ep = 1; w = {bfirst, 1'b0, fx(a)}; tg = "R6"; end
        2'b10: begin ep = 1; tg = "R7";
          w = bphase ? {bfirst, 1'b1, fx(b)} : {bfirst, 1'b0, fx(a)}; end
        2'b11: begin ep = 1; tg = "R8";
          if (!bphase) begin w = {bfirst, 1'b0, fx(a)}; bhold = fx(b); end
          else w = {bfirst, 1'b1, bhold};
        end
        default: ep = 0;
      endcase
    end
    if (bfirst) tg = {tg, " R10 first after R3 or R4 window"};
    tg = {tg, " R9"};
    pop = (bcnt != 0) && rdy;
    if (ep && (bcnt < DEPTH || pop)) begin
      acc = 1; exp_q.push_back(w); tag_q.push_back(tg);
    end
    bcnt = bcnt + int'(acc) - int'(pop);
    load = (m != bsel);
    nph = (load || bblank != 0) ? 1'b0 : ~bphase;
    if (load) bblank = (bsel == 2'b00 || (bsel == 2'b01 && m[1])) ? 10 : 5;
    else if (bblank != 0) bblank--;
    if (load) bfirst = 1; else if (ep) bfirst = 0;
    bsel = m; bphase = nph;
    @(negedge clk);
    check(adc_sel == m, "R2 adc_sel", adc_sel, m);
  endtask

  // monitor: scoreboard pop and stall check
  initial begin
    logic prev_stall;
    logic [11:0] prev_w, got, expw;
    string t;
    prev_stall = 0; prev_w = '0;
    forever begin
      @(negedge clk); #1;
      if (!rst) begin
        got = {out_first, out_chan, out_data};
        if (prev_stall)
          check(out_valid && got == prev_w, "R11 stalled word moved", got, prev_w);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(0, "R5 unexpected word", got, 0);
          end else begin
            expw = exp_q.pop_front(); t = tag_q.pop_front();
            check(got == expw, t, got, expw);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_w = got;
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired got=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(adc_sel == 2'b00, "R1 adc_sel after reset", adc_sel, 0);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    rst = 1'b0;
    repeat (30) step(2'b01, 1'b1);       // R4 wake then R6
    fmt_offset = 1'b1;
    repeat (30) step(2'b10, 1'b1);       // R4 (01 to 10) then R7 with R9
    repeat (30) step(2'b11, 1'b1);       // R3 then R8
    fmt_offset = 1'b0;
    repeat (20) step(2'b01, 1'b1);       // R3
    repeat (25) step(2'b11, 1'b1);       // R4
    repeat (8)  step(2'b11, 1'b0);       // R11 fill and drop
    repeat (10) step(2'b11, 1'b1);
    repeat (40) step(2'b10, 1'($urandom)); // R11 random back-pressure
    repeat (12) step(2'b10, 1'b1);
    repeat (20) step(2'b00, 1'b1);       // R5
    check(out_valid == 1'b0, "R5 output idle in power-down", out_valid, 0);
    repeat (10) step(2'b00, 1'b1);
    check(exp_q.size() == 0, "R3 R4 word count", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule